// File: doc/BRIEF.md
# PWM fault shutdown controller

This block guards a PWM stage against external fault signals. It watches a set of active-high fault pins. Each pin passes through a two-flop synchronizer and then a digital filter with its own setting. When the filtered level of a pin rises, the block latches a flag for that fault and drops a single PWM enable line. An external PWM counter supplies a one-cycle strobe at the start of every half period. Those strobes are the points at which most faults may let the outputs run again.

Each fault has its own recovery policy, set by a mode bit. In self-recovering mode the outputs come back at the first half-period strobe that sees the filtered level low. A software clear of the flag does not change that. In software-acknowledged mode the flag must be cleared first. What happens after the clear depends on the fault's position. Even-numbered faults with no filter come back on the first clock after the clear in which the filtered level is low. Even-numbered faults with a filter come back at the next half-period strobe, whatever the pin is doing. Odd-numbered faults come back only at a half-period strobe that finds the flag cleared and the filtered level low.

Top module: `pwm_fault_ctrl`

## Requirements
- R1: After a synchronous reset, all fault flags read 0 and `pwm_en_o` reads 1.
- R2: With filter setting 00 on a fault (bits [2i+1:2i] of `filt_sel_i`), a pin driven high just before clock edge k sets that fault's flag and drops `pwm_en_o` at edge k+3, and not earlier.
- R3: Filter settings 01, 10 and 11 need 2, 3 and 4 consecutive equal synchronized samples before the filtered level changes. A high pulse shorter than that sets no flag. A steady high under setting 11 sets the flag at edge k+6.
- R4: A flag is set on a rising filtered level and cleared by a one-cycle pulse on its bit of `flag_clr_i`. When a set and a clear fall in the same cycle, the set wins.
- R5: With the mode bit at 1 (self-recovering), the outputs disabled by that fault are enabled on the clock edge that samples `half_start_i` high while the filtered level is 0. A strobe that sees the level high does not enable them, and neither does a low level without a strobe.
- R6: In self-recovering mode a software clear resets the flag but leaves `pwm_en_o` low until the R5 condition holds.
- R7: With the mode bit at 0 on fault 0 or 2 with filter setting 00, `pwm_en_o` returns high on the first edge after the flag has been cleared at which the filtered level is 0. This happens without any half-period strobe.
- R8: With the mode bit at 0 on fault 0 or 2 with filter setting 01, 10 or 11, `pwm_en_o` returns high at the first half-period strobe after the flag has been cleared, even while the pin is still high.
- R9: With the mode bit at 0 on fault 1 or 3, `pwm_en_o` returns high only at a half-period strobe that finds the flag already cleared and the filtered level 0.
- R10: `pwm_en_o` is low while any fault still holds the outputs disabled, and it goes high only after every such fault has met its own release condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pin_i | input | 4 | Raw asynchronous fault pins, active high |
| half_start_i | input | 1 | One-cycle strobe at each PWM half-period start |
| auto_mode_i | input | 4 | Per-fault recovery mode: 1 self-recovering, 0 software-acknowledged |
| filt_sel_i | input | 8 | Two-bit filter setting per fault, fault i in bits [2i+1:2i] |
| flag_clr_i | input | 4 | Per-fault software flag clear strobe |
| fault_flag_o | output | 4 | Latched fault flags |
| pwm_en_o | output | 1 | PWM output enable, low while disabled |

## Verification
The internal state that matters is the per-fault hold bit, and the enable line shows it directly. A hold that is dropped too early makes `pwm_en_o` rise in a cycle with no strobe, or while a flag is still set. A hold that sticks keeps the line low past the edge at which the requirement says it returns. A filter counter that is off by one moves the flag edge by exactly one cycle, so the bench samples at the exact expected edge and one edge earlier. A stuck flag register shows on `fault_flag_o` one cycle after the clear strobe.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned RUN_W = SEL_W + 1;

  typedef logic [SEL_W-1:0] filt_sel_t;

  localparam filt_sel_t SEL_BYPASS = '0;

  // release schemes selected per fault position
  typedef enum logic [1:0] {
    REL_AUTO    = 2'd0,
    REL_MAN_FAST = 2'd1,
    REL_MAN_EDGE = 2'd2,
    REL_MAN_BOTH = 2'd3
  } rel_kind_t;
endpackage

// File: rtl/fault_in_filter.sv
module fault_in_filter
  import pwm_fault_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_i,
  input  filt_sel_t sel_i,
  output logic      lvl_o
);
  logic             meta_q;
  logic             sync_q;
  logic             lvl_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need;

  assign need  = {1'b0, sel_i} + RUN_W'(1);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      if (sel_i == SEL_BYPASS) begin
        lvl_q <= sync_q;
        run_q <= '0;
      end else if (sync_q == lvl_q) begin
        run_q <= '0;
      end else if (run_q + RUN_W'(1) == need) begin
        lvl_q <= sync_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

  // R3: with filtering on, a level change is backed by two matching samples
  a_r3_min_run: assert property (@(posedge clk) disable iff (rst)
    ((sel_i != SEL_BYPASS) && ($past(sel_i) != SEL_BYPASS) && (lvl_o != $past(lvl_o)))
      |-> (($past(sync_q) == lvl_o) && ($past(sync_q, 2) == lvl_o)));
endmodule

// File: rtl/fault_hold_ctrl.sv
module fault_hold_ctrl
  import pwm_fault_pkg::*;
#(
  parameter bit ODD_SLOT = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  logic      half_start_i,
  input  logic      auto_i,
  input  filt_sel_t sel_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      hold_nxt_o
);
  logic      lvl_d_q;
  logic      flag_q;
  logic      hold_q;
  logic      rise;
  logic      release_ok;
  rel_kind_t kind;

  assign rise = lvl_i & ~lvl_d_q;

  always_comb begin
    if (auto_i)                  kind = REL_AUTO;
    else if (ODD_SLOT)           kind = REL_MAN_BOTH;
    else if (sel_i == SEL_BYPASS) kind = REL_MAN_FAST;
    else                         kind = REL_MAN_EDGE;
  end

  always_comb begin
    unique case (kind)
      REL_AUTO:     release_ok = half_start_i & ~lvl_i;
      REL_MAN_FAST: release_ok = ~flag_q & ~lvl_i;
      REL_MAN_EDGE: release_ok = ~flag_q & half_start_i;
      REL_MAN_BOTH: release_ok = ~flag_q & half_start_i & ~lvl_i;
      default:      release_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (rise)            hold_nxt_o = 1'b1;
    else if (release_ok) hold_nxt_o = 1'b0;
    else                 hold_nxt_o = hold_q;
  end

  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d_q <= 1'b0;
      flag_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      hold_q  <= hold_nxt_o;
      if (rise)       flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  // R6: a self-recovering hold only drops at a strobe
  a_r6_auto_waits_strobe: assert property (@(posedge clk) disable iff (rst)
    (auto_i && hold_q && !half_start_i) |=> hold_q);

  // R9: a software-acknowledged hold survives while its flag is set
  a_r9_manual_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (!auto_i && flag_q && hold_q) |=> hold_q);
endmodule

// File: rtl/pwm_fault_ctrl.sv
module pwm_fault_ctrl
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_FAULT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_FAULT-1:0]       fault_pin_i,
  input  logic                     half_start_i,
  input  logic [N_FAULT-1:0]       auto_mode_i,
  input  logic [N_FAULT*SEL_W-1:0] filt_sel_i,
  input  logic [N_FAULT-1:0]       flag_clr_i,
  output logic [N_FAULT-1:0]       fault_flag_o,
  output logic                     pwm_en_o
);
  logic [N_FAULT-1:0] lvl;
  logic [N_FAULT-1:0] hold_nxt;
  logic [N_FAULT-1:0] fast_slot;
  logic               pwm_en_q;

  for (genvar i = 0; i < N_FAULT; i++) begin : g_fault
    filt_sel_t sel;
    assign sel = filt_sel_i[i*SEL_W +: SEL_W];
    assign fast_slot[i] = ~auto_mode_i[i] & ((i % 2) == 0) & (sel == SEL_BYPASS);

    fault_in_filter u_filt (
      .clk   (clk),
      .rst   (rst),
      .pin_i (fault_pin_i[i]),
      .sel_i (sel),
      .lvl_o (lvl[i])
    );

    fault_hold_ctrl #(.ODD_SLOT((i % 2) == 1)) u_hold (
      .clk          (clk),
      .rst          (rst),
      .lvl_i        (lvl[i]),
      .half_start_i (half_start_i),
      .auto_i       (auto_mode_i[i]),
      .sel_i        (sel),
      .clr_i        (flag_clr_i[i]),
      .flag_o       (fault_flag_o[i]),
      .hold_nxt_o   (hold_nxt[i])
    );

    // R10: a newly latched flag always coincides with disabled outputs
    a_r10_flag_disables: assert property (@(posedge clk) disable iff (rst)
      $rose(fault_flag_o[i]) |-> !pwm_en_o);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_en_q <= 1'b1;
    else     pwm_en_q <= ~|hold_nxt;
  end

  assign pwm_en_o = pwm_en_q;

  // R1: reset leaves outputs enabled and flags clear
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pwm_en_o && (fault_flag_o == '0)));

  // R5: re-enable happens at a strobe or through a fast-release slot
  a_r5_release_point: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_en_o) |-> ($past(half_start_i) || ($past(fast_slot) != '0)));
endmodule

// File: tb/pwm_fault_ctrl_tb_top.sv
module pwm_fault_ctrl_tb_top;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NF-1:0] pins;
  logic          half;
  logic [NF-1:0] amode;
  logic [2*NF-1:0] sel;
  logic [NF-1:0] clr;
  logic [NF-1:0] flags;
  logic          pwm_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_fault_ctrl #(.N_FAULT(NF)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .fault_pin_i  (pins),
    .half_start_i (half),
    .auto_mode_i  (amode),
    .filt_sel_i   (sel),
    .flag_clr_i   (clr),
    .fault_flag_o (flags),
    .pwm_en_o     (pwm_en)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_en(input string req, input logic exp);
    check(pwm_en === exp, req, "pwm_en", int'(pwm_en), int'(exp));
  endtask

  task automatic chk_flag(input string req, input int idx, input logic exp);
    check(flags[idx] === exp, req, $sformatf("flag%0d", idx), int'(flags[idx]), int'(exp));
  endtask

  task automatic do_reset();
    rst = 1'b1; pins = '0; half = 1'b0; amode = '0; sel = '0; clr = '0;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic pulse_half();
    half = 1'b1; step(1); half = 1'b0;
  endtask

  task automatic pulse_clr(input int idx);
    clr[idx] = 1'b1; step(1); clr[idx] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(flags === '0, "R1", "flags", int'(flags), 0);
    chk_en("R1", 1'b1);
  endtask

  task automatic t_bypass_latency();
    do_reset();
    amode[0] = 1'b1;
    pins[0] = 1'b1;
    step(3);
    chk_flag("R2", 0, 1'b0);
    chk_en("R2", 1'b1);
    step(1);
    chk_flag("R2", 0, 1'b1);
    chk_en("R2", 1'b0);
  endtask

  task automatic t_filter_runs();
    do_reset();
    amode = '1;
    sel[3:2] = 2'b01;
    pins[1] = 1'b1; step(1); pins[1] = 1'b0;
    step(8);
    chk_flag("R3", 1, 1'b0);
    sel[7:6] = 2'b11;
    pins[3] = 1'b1; step(3); pins[3] = 1'b0;
    step(8);
    chk_flag("R3", 3, 1'b0);
    chk_en("R3", 1'b1);
    pins[3] = 1'b1;
    step(6);
    chk_flag("R3", 3, 1'b0);
    step(1);
    chk_flag("R3", 3, 1'b1);
    chk_en("R3", 1'b0);
  endtask

  task automatic t_set_wins();
    do_reset();
    pins[0] = 1'b1;
    step(3);
    clr[0] = 1'b1; step(1); clr[0] = 1'b0;
    chk_flag("R4", 0, 1'b1);
    pulse_clr(0);
    chk_flag("R4", 0, 1'b0);
  endtask

  task automatic t_auto();
    do_reset();
    amode[0] = 1'b1;
    pins[0] = 1'b1;
    step(4);
    chk_flag("R5", 0, 1'b1);
    pulse_clr(0);
    chk_flag("R6", 0, 1'b0);
    chk_en("R6", 1'b0);
    pulse_half();
    chk_en("R5", 1'b0);
    pins[0] = 1'b0;
    step(5);
    chk_en("R5", 1'b0);
    pulse_half();
    chk_en("R5", 1'b1);
  endtask

  task automatic t_manual_fast();
    do_reset();
    pins[2] = 1'b1;
    step(4);
    chk_flag("R7", 2, 1'b1);
    pins[2] = 1'b0;
    step(4);
    chk_en("R7", 1'b0);
    pulse_clr(2);
    chk_en("R7", 1'b0);
    step(1);
    chk_en("R7", 1'b1);
    pins[2] = 1'b1;
    step(4);
    chk_en("R7", 1'b0);
    pulse_clr(2);
    step(2);
    chk_en("R7", 1'b0);
    pins[2] = 1'b0;
    step(3);
    chk_en("R7", 1'b0);
    step(1);
    chk_en("R7", 1'b1);
  endtask

  task automatic t_manual_edge();
    do_reset();
    sel[1:0] = 2'b01;
    pins[0] = 1'b1;
    step(5);
    chk_flag("R8", 0, 1'b1);
    pulse_clr(0);
    step(3);
    chk_en("R8", 1'b0);
    pulse_half();
    chk_en("R8", 1'b1);
    chk_flag("R8", 0, 1'b0);
  endtask

  task automatic t_manual_both();
    do_reset();
    pins[1] = 1'b1;
    step(4);
    chk_flag("R9", 1, 1'b1);
    pins[1] = 1'b0;
    step(4);
    pulse_half();
    chk_en("R9", 1'b0);
    pulse_clr(1);
    step(2);
    chk_en("R9", 1'b0);
    pulse_half();
    chk_en("R9", 1'b1);
    pins[3] = 1'b1;
    step(4);
    chk_flag("R9", 3, 1'b1);
    pulse_clr(3);
    pulse_half();
    chk_en("R9", 1'b0);
    pins[3] = 1'b0;
    step(3);
    pulse_half();
    chk_en("R9", 1'b1);
  endtask

  task automatic t_multi();
    do_reset();
    amode[1:0] = 2'b11;
    pins[1:0] = 2'b11;
    step(4);
    chk_en("R10", 1'b0);
    pins[0] = 1'b0;
    step(3);
    pulse_half();
    chk_en("R10", 1'b0);
    pins[1] = 1'b0;
    step(3);
    pulse_half();
    chk_en("R10", 1'b1);
    check(flags[1:0] === 2'b11, "R10", "flags", int'(flags[1:0]), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pins = '0; half = 1'b0; amode = '0; sel = '0; clr = '0;
    @(negedge clk);
    t_reset();
    t_bypass_latency();
    t_filter_runs();
    t_set_wins();
    t_auto();
    t_manual_fast();
    t_manual_edge();
    t_manual_both();
    t_multi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule